// File: doc/BRIEF.md
# Network controller initialization block loader

When software requests a start-up, the controller has to pick up its configuration from the shared buffer memory. This block does that. A one-cycle command pulse starts it. It then reads a 24-byte configuration record from a 16-bit-wide buffer memory, one word per cycle. The record's start address comes from two control-register fields.

From the record it takes:
- the operating mode word;
- the 48-bit station address;
- the 64-bit multicast hash filter;
- the base address and entry count of the receive descriptor ring;
- the base address and entry count of the transmit descriptor ring.

All of these are presented as steady outputs for the frame engines. When the last word arrives, the block does four things on the same edge:
- sets the done flag;
- drops busy;
- sets the transmit and receive enables from the mode word;
- pulses a restart strobe for one cycle.

The restart strobe tells the neighbouring engines to rewind both ring indices to entry 0 and to drop any half-built frame. A stop command aborts a load and clears the done flag.

The controller has three states:
- IDLE: waiting for a command.
- FETCH: one read is issued per cycle, twelve in all.
- DRAIN: the last read is returning.

It has four transitions:
- IDLE to FETCH on an accepted start.
- FETCH to DRAIN after the twelfth read.
- DRAIN to IDLE on completion.
- FETCH to IDLE on stop.

Top module: `init_block_loader`

## Requirements
- R1: The record start address is `{blk_addr_hi, blk_addr_lo}`, sampled on the edge that accepts the start. During the next 12 cycles `mem_rd_en` is high, and `mem_addr` is start+0, start+2, up to start+22, one per cycle. Each read returns `mem_rdata` one cycle later.
- R2: `misaligned` equals bit 0 of the accepted start address and holds until the next accepted start.
- R3: `mode_word` is word 0 of the record. `loopback` is its bit 2, and it has no effect on any other output. `station_addr` is words 1, 2 and 3, with word 1 in the least significant position.
- R4: `mcast_filter` is words 4 to 7, with word 4 in the least significant position.
- R5: `rx_ring_base` is {word 9 bits 7:0, word 8}. `tx_ring_base` is {word 11 bits 7:0, word 10}.
- R6: `rx_ring_len` is 2 raised to word 9 bits 15:13, and `tx_ring_len` is 2 raised to word 11 bits 15:13. Code 0 gives 1 and code 7 gives 128.
- R7: At completion, `txon` becomes the inverse of mode bit 1 and `rxon` becomes the inverse of mode bit 0. They change at no other time.
- R8: `idon` rises, `busy` falls and `ring_restart` pulses for exactly one cycle, all on the 13th clock edge after the edge that accepted the start.
- R9: `init_set` is ignored while `busy` is high. The read sequence and the completion time are unchanged.
- R10: `stop_set` returns the block to IDLE and clears `idon`. No completion follows. When `stop_set` and `init_set` are both high on the same edge, the stop wins and no load starts.
- R11: After reset, `busy`, `idon`, `txon`, `rxon`, `mem_rd_en` and `misaligned` are 0, and both ring lengths read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_set | input | 1 | Start-load command pulse |
| stop_set | input | 1 | Stop command pulse |
| blk_addr_lo | input | 16 | Record start address bits 15:0 |
| blk_addr_hi | input | 8 | Record start address bits 23:16 |
| mem_rd_en | output | 1 | Buffer memory read strobe |
| mem_addr | output | 24 | Buffer memory byte address |
| mem_rdata | input | 16 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Load in progress (command bit pending) |
| idon | output | 1 | Load-done flag |
| txon | output | 1 | Transmitter enable |
| rxon | output | 1 | Receiver enable |
| ring_restart | output | 1 | One-cycle strobe: rewind ring indices and drop partial frames |
| misaligned | output | 1 | Start address was odd |
| mode_word | output | 16 | Mode word |
| loopback | output | 1 | Loopback mode bit, exported only |
| station_addr | output | 48 | Station address |
| mcast_filter | output | 64 | Multicast hash filter |
| rx_ring_base | output | 24 | Receive ring base address |
| rx_ring_len | output | 8 | Receive ring entry count |
| tx_ring_base | output | 24 | Transmit ring base address |
| tx_ring_len | output | 8 | Transmit ring entry count |

## Verification
The commands that can meet in one cycle are start and stop. The bench drives both pulses on the same edge from IDLE and expects no read strobe and `busy` low afterwards.

The bench also fires a second start in the middle of a FETCH run. It judges that case by the unbroken address sequence and by completion landing on the same 13th edge.

A stop in mid-fetch is checked by `busy` and `idon` being low one cycle later, with no restart strobe after it.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN
    } ibl_state_e;

    // record layout in 16-bit words (decoded by neighbours, so fixed)
    localparam int IBL_WORDS   = 12;
    localparam int IDX_MODE    = 0;
    localparam int IDX_STATION = 1;
    localparam int IDX_FILTER  = 4;
    localparam int IDX_RXRING  = 8;
    localparam int IDX_TXRING  = 10;
endpackage

// File: rtl/ibl_ctrl.sv
module ibl_ctrl
    import ibl_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int N_WORDS = IBL_WORDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_set,
    input  logic                       stop_set,
    input  logic [ADDR_W-1:0]          blk_base,
    input  logic                       mode_no_tx,
    input  logic                       mode_no_rx,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       cap_we,
    output logic [$clog2(N_WORDS)-1:0] cap_idx,
    output logic                       busy,
    output logic                       idon,
    output logic                       txon,
    output logic                       rxon,
    output logic                       ring_restart,
    output logic                       misaligned
);
    localparam int IDX_W = $clog2(N_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    ibl_state_e        state_q, state_d;
    logic [IDX_W-1:0]  issue_cnt;
    logic [ADDR_W-1:0] base_q;
    logic              cap_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && init_set && !stop_set;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (init_set && !stop_set) state_d = ST_FETCH;
            ST_FETCH: begin
                if (stop_set)                  state_d = ST_IDLE;
                else if (issue_cnt == LAST_IDX) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs derived from state
    assign busy      = (state_q != ST_IDLE);
    assign mem_rd_en = (state_q == ST_FETCH);
    assign mem_addr  = base_q + (ADDR_W'(issue_cnt) << 1);
    assign cap_we    = cap_q && !stop_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_cnt    <= '0;
            base_q       <= '0;
            misaligned   <= 1'b0;
            cap_q        <= 1'b0;
            cap_idx      <= '0;
            idon         <= 1'b0;
            txon         <= 1'b0;
            rxon         <= 1'b0;
            ring_restart <= 1'b0;
        end else begin
            cap_q        <= (state_q == ST_FETCH) && !stop_set;
            cap_idx      <= issue_cnt;
            ring_restart <= 1'b0;
            if (accept) begin
                base_q     <= blk_base;
                misaligned <= blk_base[0];
                issue_cnt  <= '0;
            end else if (state_q == ST_FETCH) begin
                issue_cnt <= issue_cnt + 1'b1;
            end
            if (state_q == ST_DRAIN && !stop_set) begin
                idon         <= 1'b1;
                txon         <= !mode_no_tx;
                rxon         <= !mode_no_rx;
                ring_restart <= 1'b1;
            end
            if (stop_set) idon <= 1'b0;
        end
    end
endmodule

// File: rtl/ibl_word_bank.sv
module ibl_word_bank #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_WORDS)-1:0] wr_idx,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [N_WORDS*WORD_W-1:0]  words_flat
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && wr_idx == $clog2(N_WORDS)'(i))
                word_q <= wr_data;
        end
        assign words_flat[i*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/ibl_ring_decode.sv
module ibl_ring_decode #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 24,
    parameter int CODE_W = 3
) (
    input  logic [WORD_W-1:0]    lo_word,
    input  logic [WORD_W-1:0]    hi_word,
    output logic [ADDR_W-1:0]    ring_base,
    output logic [2**CODE_W-1:0] ring_len
);
    localparam int HI_BITS = ADDR_W - WORD_W;
    localparam int LEN_W   = 2 ** CODE_W;

    logic [CODE_W-1:0] code;
    assign code      = hi_word[WORD_W-1 -: CODE_W];
    assign ring_base = {hi_word[HI_BITS-1:0], lo_word};
    assign ring_len  = LEN_W'(1) << code;
endmodule

// File: rtl/init_block_loader.sv
module init_block_loader
    import ibl_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16,
    parameter int CODE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_set,
    input  logic                       stop_set,
    input  logic [WORD_W-1:0]          blk_addr_lo,
    input  logic [ADDR_W-WORD_W-1:0]   blk_addr_hi,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic                       busy,
    output logic                       idon,
    output logic                       txon,
    output logic                       rxon,
    output logic                       ring_restart,
    output logic                       misaligned,
    output logic [WORD_W-1:0]          mode_word,
    output logic                       loopback,
    output logic [3*WORD_W-1:0]        station_addr,
    output logic [4*WORD_W-1:0]        mcast_filter,
    output logic [ADDR_W-1:0]          rx_ring_base,
    output logic [2**CODE_W-1:0]       rx_ring_len,
    output logic [ADDR_W-1:0]          tx_ring_base,
    output logic [2**CODE_W-1:0]       tx_ring_len
);
    localparam int IDX_W = $clog2(IBL_WORDS);

    logic [IBL_WORDS*WORD_W-1:0] words;
    logic                        cap_we;
    logic [IDX_W-1:0]            cap_idx;

    assign mode_word    = words[IDX_MODE*WORD_W +: WORD_W];
    assign loopback     = mode_word[2];
    assign station_addr = words[IDX_STATION*WORD_W +: 3*WORD_W];
    assign mcast_filter = words[IDX_FILTER*WORD_W +: 4*WORD_W];

    ibl_ctrl #(.ADDR_W(ADDR_W), .N_WORDS(IBL_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .init_set(init_set), .stop_set(stop_set),
        .blk_base({blk_addr_hi, blk_addr_lo}),
        .mode_no_tx(mode_word[1]), .mode_no_rx(mode_word[0]),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .cap_we(cap_we), .cap_idx(cap_idx),
        .busy(busy), .idon(idon), .txon(txon), .rxon(rxon),
        .ring_restart(ring_restart), .misaligned(misaligned)
    );

    ibl_word_bank #(.WORD_W(WORD_W), .N_WORDS(IBL_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cap_we), .wr_idx(cap_idx), .wr_data(mem_rdata),
        .words_flat(words)
    );

    ibl_ring_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rx_ring (
        .lo_word(words[IDX_RXRING*WORD_W +: WORD_W]),
        .hi_word(words[(IDX_RXRING+1)*WORD_W +: WORD_W]),
        .ring_base(rx_ring_base), .ring_len(rx_ring_len)
    );

    ibl_ring_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_tx_ring (
        .lo_word(words[IDX_TXRING*WORD_W +: WORD_W]),
        .hi_word(words[(IDX_TXRING+1)*WORD_W +: WORD_W]),
        .ring_base(tx_ring_base), .ring_len(tx_ring_len)
    );
endmodule

// File: rtl/ibl_checker.sv
module ibl_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_set,
    input logic              stop_set,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              idon,
    input logic              txon,
    input logic              rxon,
    input logic              ring_restart
);
    // R1
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + ADDR_W'(2));
    // R1
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);
    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idon) |-> $past(busy) && !busy);
    // R8
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_restart |=> !ring_restart);
    // R7
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txon) || $rose(rxon)) |-> ring_restart && $past(busy));
    // R9
    init_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && init_set && !stop_set |=> busy);
    // R10
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_set |=> !busy && !idon && !ring_restart);
endmodule

bind init_block_loader ibl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_set(init_set), .stop_set(stop_set),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .busy(busy), .idon(idon),
    .txon(txon), .rxon(rxon), .ring_restart(ring_restart)
);

// File: tb/tb_init_block_loader.sv
module tb_init_block_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_set = 1'b0;
    logic        stop_set = 1'b0;
    logic [15:0] blk_addr_lo = '0;
    logic [7:0]  blk_addr_hi = '0;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, idon, txon, rxon, ring_restart, misaligned, loopback;
    logic [15:0] mode_word;
    logic [47:0] station_addr;
    logic [63:0] mcast_filter;
    logic [23:0] rx_ring_base, tx_ring_base;
    logic [7:0]  rx_ring_len, tx_ring_len;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [256];
    logic [15:0] blk [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[8:1]];

    init_block_loader dut (
        .clk(clk), .rst_n(rst_n), .init_set(init_set), .stop_set(stop_set),
        .blk_addr_lo(blk_addr_lo), .blk_addr_hi(blk_addr_hi),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .idon(idon), .txon(txon), .rxon(rxon),
        .ring_restart(ring_restart), .misaligned(misaligned),
        .mode_word(mode_word), .loopback(loopback),
        .station_addr(station_addr), .mcast_filter(mcast_filter),
        .rx_ring_base(rx_ring_base), .rx_ring_len(rx_ring_len),
        .tx_ring_base(tx_ring_base), .tx_ring_len(tx_ring_len)
    );

    function automatic logic [7:0] exp_len(input logic [15:0] hi);
        return 8'd1 << hi[15:13];
    endfunction

    function automatic logic [23:0] exp_base(input logic [15:0] lo, input logic [15:0] hi);
        return {hi[7:0], lo};
    endfunction

    function automatic logic [7:0] word_slot(input logic [23:0] base, input int k);
        logic [23:0] a;
        a = base + 24'(2 * k);
        return a[8:1];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill_random();
        for (int k = 0; k < 12; k++) blk[k] = 16'($urandom);
    endtask

    task automatic check_fields(input logic [23:0] base);
        chk(mode_word == blk[0] && loopback == blk[0][2], "R3 mode", {47'd0, loopback, mode_word}, {47'd0, blk[0][2], blk[0]});
        chk(station_addr == {blk[3], blk[2], blk[1]}, "R3 station", station_addr, {blk[3], blk[2], blk[1]});
        chk(mcast_filter == {blk[7], blk[6], blk[5], blk[4]}, "R4 filter", mcast_filter, {blk[7], blk[6], blk[5], blk[4]});
        chk(rx_ring_base == exp_base(blk[8], blk[9]) && tx_ring_base == exp_base(blk[10], blk[11]),
            "R5 ring bases", {rx_ring_base, tx_ring_base}, {exp_base(blk[8], blk[9]), exp_base(blk[10], blk[11])});
        chk(rx_ring_len == exp_len(blk[9]) && tx_ring_len == exp_len(blk[11]),
            "R6 ring lengths", {rx_ring_len, tx_ring_len}, {exp_len(blk[9]), exp_len(blk[11])});
        chk(txon == !blk[0][1] && rxon == !blk[0][0], "R7 enables", {txon, rxon}, {!blk[0][1], !blk[0][0]});
        chk(misaligned == base[0], "R2 misaligned", misaligned, base[0]);
    endtask

    // mid_init / stop_at: read slot at which to inject, -1 for none
    task automatic do_load(input logic [23:0] base, input int mid_init, input int stop_at);
        bit addr_ok;
        for (int k = 0; k < 12; k++) mem[word_slot(base, k)] = blk[k];
        @(negedge clk);
        blk_addr_lo = base[15:0];
        blk_addr_hi = base[23:16];
        init_set = 1'b1;
        @(posedge clk); @(negedge clk);
        init_set = 1'b0;
        addr_ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (k == stop_at) begin
                stop_set = 1'b1;
                @(posedge clk); @(negedge clk);
                stop_set = 1'b0;
                chk(!busy && !idon && !ring_restart, "R10 stop aborts", {busy, idon, ring_restart}, 0);
                @(posedge clk); @(negedge clk);
                chk(!busy && !mem_rd_en && !ring_restart && !idon, "R10 no completion after stop",
                    {busy, mem_rd_en, ring_restart, idon}, 0);
                return;
            end
            if (!(mem_rd_en && mem_addr == base + 24'(2 * k))) addr_ok = 1'b0;
            if (k == mid_init) init_set = 1'b1;
            @(posedge clk); @(negedge clk);
            init_set = 1'b0;
        end
        chk(addr_ok, (mid_init >= 0) ? "R9 sequence kept under start" : "R1 read sequence", addr_ok, 1);
        chk(busy && !mem_rd_en && !ring_restart, "R8 drain cycle", {busy, mem_rd_en, ring_restart}, 3'b100);
        @(posedge clk); @(negedge clk);
        chk(!busy && idon && ring_restart, "R8 completion edge", {busy, idon, ring_restart}, 3'b011);
        @(posedge clk); @(negedge clk);
        chk(!busy && !ring_restart, "R8 single restart pulse", {busy, ring_restart}, 0);
        check_fields(base);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk(!busy && !idon && !txon && !rxon && !mem_rd_en && !misaligned, "R11 reset outputs",
            {busy, idon, txon, rxon, mem_rd_en, misaligned}, 0);
        chk(rx_ring_len == 8'd1 && tx_ring_len == 8'd1, "R11 reset ring lengths", {rx_ring_len, tx_ring_len}, 16'h0101);

        // R7 each mode combination, R3 loopback no effect
        for (int m = 0; m < 5; m++) begin
            fill_random();
            blk[0] = {blk[0][15:3], 3'(m)};
            do_load(24'h00_4000 + 24'(m * 64), -1, -1);
        end

        // R6 ring length extremes
        fill_random();
        blk[9]  = {3'd0, blk[9][12:0]};
        blk[11] = {3'd7, blk[11][12:0]};
        do_load(24'h12_0100, -1, -1);
        fill_random();
        blk[9]  = {3'd7, blk[9][12:0]};
        blk[11] = {3'd0, blk[11][12:0]};
        do_load(24'hAB_FFF0, -1, -1);

        // R2 odd start
        fill_random();
        do_load(24'h03_1235, -1, -1);

        // R9 start during load ignored
        fill_random();
        do_load(24'h00_2000, 5, -1);

        // R10 stop mid-load, then stop and start on one edge
        fill_random();
        do_load(24'h00_3000, -1, 6);
        @(negedge clk);
        init_set = 1'b1;
        stop_set = 1'b1;
        @(posedge clk); @(negedge clk);
        init_set = 1'b0;
        stop_set = 1'b0;
        chk(!busy && !mem_rd_en, "R10 stop beats start", {busy, mem_rd_en}, 0);

        // random loads
        for (int n = 0; n < 20; n++) begin
            fill_random();
            do_load(24'($urandom), -1, -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule